// File: doc/BRIEF.md
# Match Timer with Deferred Clear

This block is a 32-bit up-counting timer that a processor reaches through a small register bus. Software loads a compare value, starts the counter, and gets a level interrupt when the count hits the compare value. The counter can restart from zero on each hit, which gives a periodic tick, or it can keep running and roll over at its top value, which gives a free-running time base with a one-shot alarm.

Counting is paced by a slow-domain tick input (`tick_en`), one pulse for each slow-clock period. A divider register can slow the count to one step in every four ticks. Clearing the counter does not happen at once. The request passes through two slow-tick stages, and a status flag shows the clear as in progress until it is done. While that flag is set the counter is frozen, so software waits for the flag to drop before it relies on a zero count.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero: count, compare value, control, divider and status. The interrupt output is low.
- R2: Control register (offset 0x08) bit 0 is the run bit and bit 1 is the restart-on-hit bit. The register reads back what was written to those two bits. While the run bit is 0 and no clear is pending, the count does not change. While the run bit is 1, each counting step adds one.
- R3: The count register (offset 0x04) is read only. A write to it leaves the count unchanged.
- R4: A write of any value to offset 0x0C requests a clear. The counter holds its value on the first slow tick after the request and becomes zero on the second slow tick. Counting resumes with the tick after that.
- R5: Writing exactly 0x3 to the divider register (offset 0x10) makes the counter advance once every 4 slow ticks. Any other value selects one step for each tick. The register reads back 0x3 or 0 to match. Writing the register restarts the divide-by-4 phase, so 4 more ticks are needed before the next step.
- R6: On a counting step while the run bit is 1, if the count before the step equals the compare value (offset 0x00), a sticky interrupt flag is set and drives `irq` high from the next cycle.
- R7: With the restart-on-hit bit set, the step that hits the compare value loads zero instead of adding one. For a compare value M and a start at zero, the period is M+1 steps.
- R8: Writing the control register with bit 0 low clears the interrupt flag. When such a write falls in the same cycle as a hit, the clear wins. A write with bit 0 high leaves the flag as it is.
- R9: With restart-on-hit off, the counter wraps from its all-ones value to zero.
- R10: A stopped timer never sets the interrupt flag, even when the count equals the compare value and ticks arrive.
- R11: Bit 10 of the status word (offset 0x14) reads 1 from the cycle after a clear request until the clear completes. It reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per slow-domain period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register being accessed |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt, high while the hit flag is set |

## Verification
Two functions can act on the same cycle: a counting step that hits the compare value, and a control-register write that touches the interrupt flag. The bench brings the count up to one below the hit. It then raises `tick_en` and the control write strobe in one single cycle, once with the run bit cleared and once with it set. A write that stops the timer must leave `irq` low even though the count still advanced past the compare value. A write that keeps the timer running must let the hit raise `irq`. The same case of a clear request against a slow tick is covered by sweeps that read the status flag and the count after each tick.

// File: rtl/mt_pkg.sv
// Shared constants for the match timer: register offsets, status bit
// position and the divider code. Assumes an 8-bit byte-offset bus.
package mt_pkg;
    localparam int MT_ADDR_W = 8;
    typedef logic [MT_ADDR_W-1:0] mt_addr_t;

    localparam mt_addr_t MT_A_MATCH = 8'h00;
    localparam mt_addr_t MT_A_COUNT = 8'h04;
    localparam mt_addr_t MT_A_CTRL  = 8'h08;
    localparam mt_addr_t MT_A_CLEAR = 8'h0C;
    localparam mt_addr_t MT_A_DIV   = 8'h10;
    localparam mt_addr_t MT_A_STAT  = 8'h14;

    localparam int MT_PEND_BIT  = 10;
    localparam int MT_DIV4_CODE = 3;
endpackage

// File: rtl/mt_prescale.sv
// Step generator: passes the slow tick straight through, or one tick in
// every 2**DIV_LOG2 when div_on is set. phase_rst restarts the phase.
// Assumes tick_en is a single-cycle pulse.
module mt_prescale #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic div_on,
    input  logic phase_rst,
    output logic step
);
    logic [DIV_LOG2-1:0] phase_q;

    // Advance the divide phase on each slow tick while dividing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_rst)
            phase_q <= '0;
        else if (tick_en && div_on)
            phase_q <= phase_q + 1'b1;
    end

    // A step occurs on every tick, or on the last tick of a phase cycle.
    always_comb begin
        step = tick_en && (!div_on || (phase_q == '1));
    end
endmodule

// File: rtl/mt_clear_sync.sv
// Deferred clear: a request starts a countdown of STAGES slow ticks.
// pending is high for the whole countdown. done pulses on the tick that
// ends it. A new request restarts the countdown.
module mt_clear_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic clr_req,
    output logic pending,
    output logic done
);
    localparam int CW = $clog2(STAGES + 1);
    logic [CW-1:0] left_q;

    // Load the countdown on request, then count it down on slow ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (clr_req)
            left_q <= CW'(STAGES);
        else if (tick_en && (left_q != '0))
            left_q <= left_q - 1'b1;
    end

    // Decode pending and completion from the countdown state.
    always_comb begin
        pending = (left_q != '0);
        done    = tick_en && !clr_req && (left_q == CW'(1));
    end
endmodule

// File: rtl/mt_counter.sv
// Counter core: adds one on each step while running and not held. It loads
// zero on clr_now, or on a hit when restart is set. hit flags a step taken
// while the count equals the compare value.
module mt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             run,
    input  logic             restart,
    input  logic             hold,
    input  logic             clr_now,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] count_q;
    logic             adv;

    // Qualify a step and detect a hit on it.
    always_comb begin
        adv = step && run && !hold;
        hit = adv && (count_q == cmp_val);
    end

    // Update the count: forced clear, restart on hit, or add one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (clr_now)
            count_q <= '0;
        else if (adv)
            count_q <= (hit && restart) ? '0 : count_q + 1'b1;
    end

    assign count = count_q;
endmodule

// File: rtl/match_timer.sv
// Match timer top: register decode, control and divider storage, the
// sticky interrupt flag and the read mux. Assumes single-cycle writes and
// a combinational read of the addressed register.
module match_timer
    import mt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 32,
    parameter int DIV_LOG2 = 2,
    parameter int STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] count_q;
    logic             ctl_en;
    logic             ctl_restart;
    logic             div4_q;
    logic             irq_q;
    logic             clr_pending;
    logic             clr_done;
    logic             step;
    logic             hit;
    logic             wr_cmp, wr_ctl, wr_clr, wr_div;

    // Decode write strobes per register.
    always_comb begin
        wr_cmp = reg_wr && (reg_addr == MT_A_MATCH);
        wr_ctl = reg_wr && (reg_addr == MT_A_CTRL);
        wr_clr = reg_wr && (reg_addr == MT_A_CLEAR);
        wr_div = reg_wr && (reg_addr == MT_A_DIV);
    end

    // Hold the compare, control and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q       <= '0;
            ctl_en      <= 1'b0;
            ctl_restart <= 1'b0;
            div4_q      <= 1'b0;
        end else begin
            if (wr_cmp) cmp_q <= reg_wdata[CNT_W-1:0];
            if (wr_ctl) begin
                ctl_en      <= reg_wdata[0];
                ctl_restart <= reg_wdata[1];
            end
            if (wr_div) div4_q <= (reg_wdata == DATA_W'(MT_DIV4_CODE));
        end
    end

    // Sticky hit flag: a stopping control write wins over a hit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (wr_ctl && !reg_wdata[0])
            irq_q <= 1'b0;
        else if (hit)
            irq_q <= 1'b1;
    end

    mt_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .div_on(div4_q), .phase_rst(wr_div), .step(step)
    );

    mt_clear_sync #(.STAGES(STAGES)) u_clr (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .clr_req(wr_clr), .pending(clr_pending), .done(clr_done)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .run(ctl_en),
        .restart(ctl_restart), .hold(clr_pending), .clr_now(clr_done),
        .cmp_val(cmp_q), .count(count_q), .hit(hit)
    );

    // Select read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            MT_A_MATCH: reg_rdata[CNT_W-1:0] = cmp_q;
            MT_A_COUNT: reg_rdata[CNT_W-1:0] = count_q;
            MT_A_CTRL:  reg_rdata[1:0] = {ctl_restart, ctl_en};
            MT_A_DIV:   reg_rdata = div4_q ? DATA_W'(MT_DIV4_CODE) : '0;
            MT_A_STAT:  reg_rdata[MT_PEND_BIT] = clr_pending;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = irq_q;
endmodule

// File: rtl/mt_checker.sv
// Temporal checks on the match timer, bound to every instance.
module mt_checker
    import mt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_wr,
    input logic [7:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count_q,
    input logic              pend,
    input logic              en
);
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !pend) |=> $stable(count_q));

    a_r4_pend_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (count_q == $past(count_q)) || (count_q == '0));

    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == MT_A_CTRL && !reg_wdata[0]) |=> !irq);

    a_r10_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !irq) |=> !irq);

    a_r6_irq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_en && en));

    a_r11_pend_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(reg_wr && reg_addr == MT_A_CLEAR));
endmodule

bind match_timer mt_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq),
    .count_q(count_q), .pend(clr_pending), .en(ctl_en)
);

// File: tb/test_match_timer.sv
module test_match_timer;
    localparam logic [7:0] A_MATCH = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                           A_CLEAR = 8'h0C, A_DIV = 8'h10, A_STAT = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata, rdata_s;
    logic        irq, irq_s;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    match_timer i_match_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata), .irq(irq)
    );

    match_timer #(.CNT_W(8)) i_match_timer_small (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .irq(irq_s)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    // Control write and slow tick in one cycle.
    task automatic wr_with_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic restart_zero();
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_CLEAR, 32'h0);
        ticks(2);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_COUNT, v); check("R1 count", v, 0);
        rd(A_MATCH, v); check("R1 match", v, 0);
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_DIV, v);   check("R1 div", v, 0);
        rd(A_STAT, v);  check("R1 status", v, 0);
        check("R1 irq", irq, 0);

        // R10: stopped timer with count == compare never interrupts
        ticks(5);
        rd(A_COUNT, v); check("R10 count held", v, 0);
        check("R10 irq", irq, 0);

        // R2: run bit, readback and one step per tick
        bus_wr(A_MATCH, 32'hFFFF_0000);
        bus_wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 1);
        ticks(7);
        rd(A_COUNT, v); check("R2 count 7", v, 7);
        bus_wr(A_CTRL, 32'h0);
        ticks(4);
        rd(A_COUNT, v); check("R2 held when off", v, 7);

        // R3: count is read only
        bus_wr(A_COUNT, 32'h55);
        rd(A_COUNT, v); check("R3 write ignored", v, 7);

        // R4 / R11: deferred clear with counting held
        bus_wr(A_CTRL, 32'h1);
        bus_wr(A_CLEAR, 32'hDEAD);
        rd(A_STAT, v); check("R11 pending set", v, 32'h400);
        ticks(1);
        rd(A_STAT, v); check("R11 pending after 1 tick", v, 32'h400);
        rd(A_COUNT, v); check("R4 held during pending", v, 7);
        ticks(1);
        rd(A_STAT, v); check("R11 pending dropped", v, 0);
        rd(A_COUNT, v); check("R4 zero after clear", v, 0);
        ticks(1);
        rd(A_COUNT, v); check("R4 resumes", v, 1);

        // R7 / R6: restart-on-hit sweep over compare values
        for (int m = 0; m < 6; m++) begin
            restart_zero();
            check("R8 irq off after stop", irq, 0);
            bus_wr(A_MATCH, m);
            bus_wr(A_CTRL, 32'h3);
            ticks(m);
            rd(A_COUNT, v); check("R7 before hit", v, m);
            check("R6 no irq before hit", irq, 0);
            ticks(1);
            rd(A_COUNT, v); check("R7 restart to zero", v, 0);
            check("R6 irq on hit", irq, 1);
        end

        // R6: free-running hit, flag stays set
        restart_zero();
        bus_wr(A_MATCH, 3);
        bus_wr(A_CTRL, 32'h1);
        ticks(4);
        rd(A_COUNT, v); check("R6 count passes compare", v, 4);
        check("R6 irq set", irq, 1);
        ticks(3);
        check("R6 irq sticky", irq, 1);

        // R8: same-cycle hit and stopping write, clear wins
        restart_zero();
        bus_wr(A_MATCH, 2);
        bus_wr(A_CTRL, 32'h1);
        ticks(2);
        check("R8 no irq yet", irq, 0);
        wr_with_tick(A_CTRL, 32'h0);
        rd(A_COUNT, v); check("R8 count stepped", v, 3);
        check("R8 stop wins over hit", irq, 0);
        // R8: same-cycle hit and running write, hit sets
        restart_zero();
        bus_wr(A_CTRL, 32'h1);
        ticks(2);
        wr_with_tick(A_CTRL, 32'h1);
        check("R8 hit with run write", irq, 1);
        bus_wr(A_CTRL, 32'h1);
        check("R8 run write keeps flag", irq, 1);
        bus_wr(A_CTRL, 32'h0);
        check("R8 stop write clears", irq, 0);

        // R5: divider code sweep
        for (int k = 0; k < 5; k++) begin
            logic [31:0] code;
            code = (k == 4) ? 32'h7 : k;
            restart_zero();
            bus_wr(A_MATCH, 32'hFFFF_0000);
            bus_wr(A_DIV, code);
            rd(A_DIV, v); check("R5 div readback", v, (code == 3) ? 3 : 0);
            bus_wr(A_CTRL, 32'h1);
            ticks(12);
            rd(A_COUNT, v); check("R5 div rate", v, (code == 3) ? 3 : 12);
        end
        // R5: phase restart on divider write
        restart_zero();
        bus_wr(A_DIV, 32'h3);
        bus_wr(A_CTRL, 32'h1);
        ticks(2);
        bus_wr(A_DIV, 32'h3);
        ticks(3);
        rd(A_COUNT, v); check("R5 phase restarted", v, 0);
        ticks(1);
        rd(A_COUNT, v); check("R5 step after 4", v, 1);
        bus_wr(A_DIV, 32'h0);

        // R9: wrap on the 8-bit instance, 32-bit keeps counting
        restart_zero();
        bus_wr(A_MATCH, 32'h1000);
        bus_wr(A_CTRL, 32'h1);
        ticks(255);
        @(negedge clk); reg_addr = A_COUNT;
        #1 check("R9 small at top", rdata_s, 32'hFF);
        ticks(1);
        @(negedge clk); reg_addr = A_COUNT;
        #1 check("R9 small wrapped", rdata_s, 0);
        check("R9 wide continues", rdata, 256);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule